// File: doc/BRIEF.md
# On-Screen Text Raster Timing Generator

This block sits at the front of an on-screen display pipeline. It runs on the dot clock, watches single-cycle horizontal and vertical sync pulses, and decides for every dot clock whether the current dot falls inside a rectangular text window. The window holds a grid of character cells. Inside the window the block reports which cell column and cell row the dot belongs to, and where the dot sits inside that cell: its dot column and its dot line. Downstream logic uses these coordinates to address character memory and font storage. Outside the window every coordinate output is zero.

The window position comes from two 6-bit start codes. The horizontal start is counted in dot clocks after horizontal sync: four clocks per step of the code, plus a base offset of 9 to 12 clocks that a 2-bit code selects. The vertical start is counted in scan lines after vertical sync: four lines per step of the code. Each dot can be stretched by 1x to 4x in either direction. The top text row has its own pair of stretch codes. All other rows share a second pair. A display-enable input blanks the whole window.

Top module: `osd_raster_timing`

## Requirements
- R1: While reset is held, and in the first cycle after reset, win_active_o is 0 and col_o, row_o, dot_x_o and dot_y_o are all 0.
- R2: Let S = STEP*h_start_i + OFS_BASE + h_ofs_i, where STEP = 4 and OFS_BASE = 9, so h_ofs_i codes 0..3 give offsets 9..12. Count the cycle that follows the clock edge sampling hsync_i high as cycle 0. On an enabled line, win_active_o first goes high in cycle S+1.
- R3: A stretch code c gives a factor m = c+1. In row 0, win_active_o stays high for COLS*CELL_W*m cycles. With rel = cycle - (S+1), the outputs are dot_x_o = (rel/m) mod CELL_W and col_o = rel/(m*CELL_W). So each dot is held for m clocks.
- R4: Count the hsync pulses that follow vsync_i from 0. With V = STEP*v_start_i, the first line on which the window can open is the one that begins with pulse number V.
- R5: The window covers CELL_H*m0 lines for row 0 and CELL_H*m1 lines for each later row. The dot_y_o output advances once every m lines and wraps at CELL_H, and row_o advances after CELL_H*m lines.
- R6: Row 0 takes its horizontal and vertical factors from row0_hmag_i and row0_vmag_i. Rows 1 to ROWS-1 take theirs from rest_hmag_i and rest_vmag_i.
- R7: disp_en_i is registered. When disp_en_i was low at a clock edge, win_active_o is low in the cycle that follows that edge.
- R8: Whenever win_active_o is 0, col_o, row_o, dot_x_o and dot_y_o are all 0.
- R9: An hsync pulse ends any horizontal run that is still open, and the next line starts again from column 0. A vsync pulse closes the window and restarts the vertical count, even if the previous frame never finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hsync_i | input | 1 | Horizontal sync, one-cycle pulse |
| vsync_i | input | 1 | Vertical sync, one-cycle pulse |
| h_start_i | input | POS_W | Horizontal start code |
| h_ofs_i | input | 2 | Horizontal base-offset code (adds 0..3 to OFS_BASE) |
| v_start_i | input | POS_W | Vertical start code |
| row0_hmag_i | input | 2 | Horizontal stretch code for row 0 |
| row0_vmag_i | input | 2 | Vertical stretch code for row 0 |
| rest_hmag_i | input | 2 | Horizontal stretch code for rows 1 and up |
| rest_vmag_i | input | 2 | Vertical stretch code for rows 1 and up |
| disp_en_i | input | 1 | Display enable |
| win_active_o | output | 1 | Current dot lies inside the text window |
| col_o | output | $clog2(COLS) | Cell column |
| row_o | output | $clog2(ROWS) | Cell row |
| dot_x_o | output | $clog2(CELL_W) | Dot column inside the cell |
| dot_y_o | output | $clog2(CELL_H) | Dot line inside the cell |

## Verification
The assertions check these properties on every cycle:
- a low display enable always blanks the next cycle;
- hsync always closes the horizontal run, and vsync always resets the row state;
- a horizontal run opens only in the cycle after the line counter met its target, and it opens at the origin;
- the row and dot-line state cannot move between sync pulses;
- the column stays inside the grid.

Exact start cycles, window widths and heights, the dot-repeat pattern for each stretch factor, and the switch between the row-0 factors and the later-row factors are arithmetic facts about whole frames. Only the bench sweeps show them, by comparing every cycle of each swept frame against values computed from the requirements.

// File: rtl/osd_timing_pkg.sv
// Package: shared types and helpers for the on-screen text raster timing.
// Assumes stretch codes 0..3 mean factors 1..4.
package osd_timing_pkg;

    typedef logic [1:0] mag_code_t;

    // Pick the stretch code for the current row: row 0 has its own code.
    function automatic mag_code_t pick_mag(input logic first_row,
                                           input mag_code_t first_code,
                                           input mag_code_t rest_code);
        return first_row ? first_code : rest_code;
    endfunction

endpackage

// File: rtl/osd_sat_counter.sv
// Module: saturating up-counter with synchronous clear.
// Assumes clear has priority over increment. The count holds at all-ones.
module osd_sat_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);

    // Count events since the last clear, holding at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc && (cnt != {W{1'b1}})) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/osd_hwalk.sv
// Module: horizontal walker. It opens a run when the clock-in-line counter
// meets the start target, then steps the dot repeat, the dot column and the
// cell column. It assumes hcnt_i saturates above any reachable target, so a
// run opens at most once per line. hsync_i always closes the run.
module osd_hwalk
    import osd_timing_pkg::*;
#(
    parameter int COLS   = 30,
    parameter int CELL_W = 12,
    parameter int HC_W   = 9,
    localparam int COL_W = $clog2(COLS),
    localparam int DX_W  = $clog2(CELL_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hsync_i,
    input  logic [HC_W-1:0]  hcnt_i,
    input  logic [HC_W-1:0]  hs_tgt_i,
    input  mag_code_t        mag_i,
    output logic             run_o,
    output logic [COL_W-1:0] col_o,
    output logic [DX_W-1:0]  dx_o
);

    localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS - 1);
    localparam logic [DX_W-1:0]  DX_LAST  = DX_W'(CELL_W - 1);

    logic             run_q;
    logic [1:0]       rep_q;
    logic [COL_W-1:0] col_q;
    logic [DX_W-1:0]  dx_q;

    // Open, step and close the horizontal run for one scan line.
    always_ff @(posedge clk) begin
        if (!rst_n || hsync_i) begin
            run_q <= 1'b0;
            rep_q <= '0;
            col_q <= '0;
            dx_q  <= '0;
        end else if (!run_q) begin
            if (hcnt_i == hs_tgt_i) begin
                run_q <= 1'b1;
            end
        end else if (rep_q >= mag_i) begin
            rep_q <= '0;
            if (dx_q == DX_LAST) begin
                dx_q <= '0;
                if (col_q == COL_LAST) begin
                    col_q <= '0;
                    run_q <= 1'b0;
                end else begin
                    col_q <= col_q + 1'b1;
                end
            end else begin
                dx_q <= dx_q + 1'b1;
            end
        end else begin
            rep_q <= rep_q + 1'b1;
        end
    end

    assign run_o = run_q;
    assign col_o = col_q;
    assign dx_o  = dx_q;

    // R9: a horizontal sync pulse always ends the run.
    a_r9_hsync_closes: assert property (@(posedge clk) disable iff (!rst_n)
        hsync_i |=> !run_q);

    // R2: a run opens only in the cycle after the counter met its target.
    a_r2_open_on_target: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_q) |-> $past(hcnt_i == hs_tgt_i));

    // R3: every run begins at the cell origin.
    a_r3_start_origin: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_q) |-> (col_q == '0 && dx_q == '0 && rep_q == '0));

    // R3: the column never leaves the grid.
    a_r3_col_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (int'(col_q) < COLS && int'(dx_q) < CELL_W));

endmodule

// File: rtl/osd_vwalk.sv
// Module: vertical walker. It advances once per horizontal sync. It opens the
// window on the line whose sync count equals the target, then steps the line
// repeat, the dot line and the cell row. Row 0 uses its own stretch code.
// It assumes lcnt_i saturates above any reachable target. vsync_i resets it.
module osd_vwalk
    import osd_timing_pkg::*;
#(
    parameter int ROWS   = 12,
    parameter int CELL_H = 18,
    parameter int LC_W   = 8,
    localparam int ROW_W = $clog2(ROWS),
    localparam int DY_W  = $clog2(CELL_H)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hsync_i,
    input  logic             vsync_i,
    input  logic [LC_W-1:0]  lcnt_i,
    input  logic [LC_W-1:0]  vs_tgt_i,
    input  mag_code_t        mag_first_i,
    input  mag_code_t        mag_rest_i,
    output logic             run_o,
    output logic [ROW_W-1:0] row_o,
    output logic [DY_W-1:0]  dy_o
);

    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);
    localparam logic [DY_W-1:0]  DY_LAST  = DY_W'(CELL_H - 1);

    logic             run_q;
    logic [1:0]       rep_q;
    logic [ROW_W-1:0] row_q;
    logic [DY_W-1:0]  dy_q;
    mag_code_t        mag_cur;

    // Select the vertical stretch code for the row now being drawn.
    always_comb mag_cur = pick_mag(row_q == '0, mag_first_i, mag_rest_i);

    // Open, step and close the vertical run, one step per scan line.
    always_ff @(posedge clk) begin
        if (!rst_n || vsync_i) begin
            run_q <= 1'b0;
            rep_q <= '0;
            row_q <= '0;
            dy_q  <= '0;
        end else if (hsync_i) begin
            if (!run_q) begin
                if (lcnt_i == vs_tgt_i) begin
                    run_q <= 1'b1;
                end
            end else if (rep_q >= mag_cur) begin
                rep_q <= '0;
                if (dy_q == DY_LAST) begin
                    dy_q <= '0;
                    if (row_q == ROW_LAST) begin
                        row_q <= '0;
                        run_q <= 1'b0;
                    end else begin
                        row_q <= row_q + 1'b1;
                    end
                end else begin
                    dy_q <= dy_q + 1'b1;
                end
            end else begin
                rep_q <= rep_q + 1'b1;
            end
        end
    end

    assign run_o = run_q;
    assign row_o = row_q;
    assign dy_o  = dy_q;

    // R9: vertical sync closes the window and returns to row 0.
    a_r9_vsync_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        vsync_i |=> (!run_q && row_q == '0 && dy_q == '0));

    // R5: row and dot line hold still between sync pulses.
    a_r5_line_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (!hsync_i && !vsync_i) |=> ($stable(row_q) && $stable(dy_q)));

endmodule

// File: rtl/osd_raster_timing.sv
// Module: top of the on-screen text raster timing generator. It counts clocks
// since horizontal sync and lines since vertical sync, derives the start
// targets from the position codes, and runs the two walkers. The window flag
// combines both runs with a registered display enable. Coordinates read zero
// outside the window. It assumes sync inputs are single-cycle pulses on clk.
module osd_raster_timing
    import osd_timing_pkg::*;
#(
    parameter int COLS     = 30,
    parameter int ROWS     = 12,
    parameter int CELL_W   = 12,
    parameter int CELL_H   = 18,
    parameter int POS_W    = 6,
    parameter int STEP     = 4,
    parameter int OFS_BASE = 9
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      hsync_i,
    input  logic                      vsync_i,
    input  logic [POS_W-1:0]          h_start_i,
    input  logic [1:0]                h_ofs_i,
    input  logic [POS_W-1:0]          v_start_i,
    input  logic [1:0]                row0_hmag_i,
    input  logic [1:0]                row0_vmag_i,
    input  logic [1:0]                rest_hmag_i,
    input  logic [1:0]                rest_vmag_i,
    input  logic                      disp_en_i,
    output logic                      win_active_o,
    output logic [$clog2(COLS)-1:0]   col_o,
    output logic [$clog2(ROWS)-1:0]   row_o,
    output logic [$clog2(CELL_W)-1:0] dot_x_o,
    output logic [$clog2(CELL_H)-1:0] dot_y_o
);

    localparam int HS_MAX = STEP * (2**POS_W - 1) + OFS_BASE + 3;
    localparam int VS_MAX = STEP * (2**POS_W - 1);
    localparam int HC_W   = $clog2(HS_MAX + 2);
    localparam int LC_W   = $clog2(VS_MAX + 2);
    localparam int COL_W  = $clog2(COLS);
    localparam int ROW_W  = $clog2(ROWS);
    localparam int DX_W   = $clog2(CELL_W);
    localparam int DY_W   = $clog2(CELL_H);

    logic [HC_W-1:0]  hcnt;
    logic [LC_W-1:0]  lcnt;
    logic [HC_W-1:0]  hs_tgt;
    logic [LC_W-1:0]  vs_tgt;
    logic             h_run, v_run, en_q;
    logic [COL_W-1:0] col_w;
    logic [ROW_W-1:0] row_w;
    logic [DX_W-1:0]  dx_w;
    logic [DY_W-1:0]  dy_w;
    mag_code_t        hmag_cur;

    // Start targets: four units per position step, plus the base offset horizontally.
    assign hs_tgt = HC_W'(STEP) * HC_W'(h_start_i) + HC_W'(OFS_BASE) + HC_W'(h_ofs_i);
    assign vs_tgt = LC_W'(STEP) * LC_W'(v_start_i);

    // Horizontal stretch follows the row that the vertical walker reports.
    always_comb hmag_cur = pick_mag(row_w == '0, mag_code_t'(row0_hmag_i),
                                    mag_code_t'(rest_hmag_i));

    osd_sat_counter #(.W(HC_W)) u_clk_in_line (
        .clk(clk), .rst_n(rst_n), .clr(hsync_i), .inc(1'b1), .cnt(hcnt)
    );

    osd_sat_counter #(.W(LC_W)) u_line_in_frame (
        .clk(clk), .rst_n(rst_n), .clr(vsync_i), .inc(hsync_i), .cnt(lcnt)
    );

    osd_hwalk #(.COLS(COLS), .CELL_W(CELL_W), .HC_W(HC_W)) u_hwalk (
        .clk(clk), .rst_n(rst_n), .hsync_i(hsync_i), .hcnt_i(hcnt),
        .hs_tgt_i(hs_tgt), .mag_i(hmag_cur),
        .run_o(h_run), .col_o(col_w), .dx_o(dx_w)
    );

    osd_vwalk #(.ROWS(ROWS), .CELL_H(CELL_H), .LC_W(LC_W)) u_vwalk (
        .clk(clk), .rst_n(rst_n), .hsync_i(hsync_i), .vsync_i(vsync_i),
        .lcnt_i(lcnt), .vs_tgt_i(vs_tgt),
        .mag_first_i(mag_code_t'(row0_vmag_i)), .mag_rest_i(mag_code_t'(rest_vmag_i)),
        .run_o(v_run), .row_o(row_w), .dy_o(dy_w)
    );

    // Register the display enable so that it lines up with the walker state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else begin
            en_q <= disp_en_i;
        end
    end

    // Gate the window and zero the coordinates outside it.
    always_comb begin
        win_active_o = h_run & v_run & en_q;
        col_o        = win_active_o ? col_w : '0;
        row_o        = win_active_o ? row_w : '0;
        dot_x_o      = win_active_o ? dx_w  : '0;
        dot_y_o      = win_active_o ? dy_w  : '0;
    end

    // R7: display enable low at an edge blanks the following cycle.
    a_r7_disp_off: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_en_i |=> !win_active_o);

endmodule

// File: tb/osd_raster_timing_test.sv
module osd_raster_timing_test;

    localparam int COLS = 3, ROWS = 2, CELL_W = 3, CELL_H = 2;
    localparam int POS_W = 3, STEP = 4, OFS = 9, LINE = 90;

    logic clk = 1'b0, rst_n = 1'b0, hsync = 1'b0, vsync = 1'b0, en = 1'b0;
    logic [POS_W-1:0] h_start = '0, v_start = '0;
    logic [1:0] h_ofs = '0, hm0 = '0, vm0 = '0, hm1 = '0, vm1 = '0;
    logic win;
    logic [$clog2(COLS)-1:0]   col;
    logic [$clog2(ROWS)-1:0]   row;
    logic [$clog2(CELL_W)-1:0] dx;
    logic [$clog2(CELL_H)-1:0] dy;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    osd_raster_timing #(.COLS(COLS), .ROWS(ROWS), .CELL_W(CELL_W), .CELL_H(CELL_H),
                        .POS_W(POS_W), .STEP(STEP), .OFS_BASE(OFS)) uut (
        .clk(clk), .rst_n(rst_n), .hsync_i(hsync), .vsync_i(vsync),
        .h_start_i(h_start), .h_ofs_i(h_ofs), .v_start_i(v_start),
        .row0_hmag_i(hm0), .row0_vmag_i(vm0), .rest_hmag_i(hm1), .rest_vmag_i(vm1),
        .disp_en_i(en), .win_active_o(win), .col_o(col), .row_o(row),
        .dot_x_o(dx), .dot_y_o(dy)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Drive inputs, pass one rising edge, settle away from the edge.
    task automatic step(input bit h, input bit v, input bit e);
        hsync = h; vsync = v; en = e;
        @(posedge clk);
        #5;
    endtask

    // One frame: a vsync cycle, then nl lines of len clocks, checked every cycle.
    task automatic run_frame(input int nl, input int len, input int enmode, input string ovr);
        int vs, hsp, m0v, m1v, m0h, m1h, htot;
        vs  = STEP * int'(v_start);
        hsp = STEP * int'(h_start) + OFS + int'(h_ofs);
        m0v = int'(vm0) + 1; m1v = int'(vm1) + 1;
        m0h = int'(hm0) + 1; m1h = int'(hm1) + 1;
        htot = CELL_H * m0v + (ROWS - 1) * CELL_H * m1v;
        step(0, 1, enmode != 1);
        chk("R9 vsync closes window", int'(win), 0);
        for (int l = 0; l < nl; l++) begin
            for (int j = 0; j < len; j++) begin
                bit e, vin, hin, act;
                int rl, er, edy, hm, w, rel, ecol, edx;
                string t;
                e = (enmode == 0) ? 1'b1 : (enmode == 1) ? 1'b0
                    : !((l % 2 == 1) && ((j / 5) % 2 == 1));
                step(j == 0, 0, e);
                vin = (l >= vs) && (l < vs + htot);
                rl = l - vs; er = 0; edy = 0;
                if (vin) begin
                    if (rl < CELL_H * m0v) begin
                        er = 0; edy = rl / m0v;
                    end else begin
                        rl = rl - CELL_H * m0v;
                        er = 1 + rl / (CELL_H * m1v);
                        edy = (rl / m1v) % CELL_H;
                    end
                end
                hm = (er > 0) ? m1h : m0h;
                w = COLS * CELL_W * hm;
                hin = (j >= hsp + 1) && (j <= hsp + w);
                rel = j - hsp - 1;
                edx = hin ? (rel / hm) % CELL_W : 0;
                ecol = hin ? rel / (hm * CELL_W) : 0;
                act = vin && hin && e;
                t = (ovr != "") ? ovr : (!e ? "R7" : (!vin ? "R4" : "R2"));
                chk({t, " win_active"}, int'(win), int'(act));
                if (act) begin
                    t = (ovr != "") ? ovr : ((er > 0) ? "R6" : "R3");
                    chk({t, " col"}, int'(col), ecol);
                    chk({t, " dot_x"}, int'(dx), edx);
                    t = (ovr != "") ? ovr : ((er > 0) ? "R6" : "R5");
                    chk({t, " row"}, int'(row), er);
                    chk({t, " dot_y"}, int'(dy), edy);
                end else begin
                    chk("R8 idle col", int'(col), 0);
                    chk("R8 idle row", int'(row), 0);
                    chk("R8 idle dot_x", int'(dx), 0);
                    chk("R8 idle dot_y", int'(dy), 0);
                end
            end
        end
    endtask

    task automatic set_cfg(input int i);
        h_start = POS_W'((i * 5) % 8);
        h_ofs   = 2'(i % 4);
        v_start = POS_W'((i * 3) % 8);
        hm0 = 2'(i % 4);
        hm1 = 2'((i / 4) % 4);
        vm0 = 2'((i / 2) % 4);
        vm1 = 2'(3 - (i % 4));
    endtask

    function automatic int frame_lines();
        return STEP * int'(v_start) + CELL_H * (int'(vm0) + 1)
               + (ROWS - 1) * CELL_H * (int'(vm1) + 1) + 2;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        repeat (3) step(0, 0, 1);
        chk("R1 reset win", int'(win), 0);
        chk("R1 reset col", int'(col), 0);
        chk("R1 reset row", int'(row), 0);
        rst_n = 1'b1;
        step(0, 0, 1);
        chk("R1 after reset win", int'(win), 0);
        chk("R1 after reset dot_x", int'(dx), 0);
        chk("R1 after reset dot_y", int'(dy), 0);
        // R2..R6: sweep positions, offsets and all stretch codes.
        for (int i = 0; i < 16; i++) begin
            set_cfg(i);
            run_frame(frame_lines(), LINE, 0, "");
        end
        // R7: display held off, then chopped inside the window.
        set_cfg(5);
        run_frame(frame_lines(), LINE, 1, "");
        set_cfg(6);
        run_frame(frame_lines(), LINE, 2, "");
        // R9: lines shorter than the window, then a frame cut early.
        set_cfg(15);
        run_frame(frame_lines(), STEP * int'(h_start) + OFS + int'(h_ofs) + 6, 0, "R9");
        set_cfg(9);
        run_frame(STEP * int'(v_start) + 3, LINE, 0, "R9");
        run_frame(frame_lines(), LINE, 0, "R9");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule